// File: doc/BRIEF.md
# Command Queue Register-Write Processor

This block drains a command ring held in local memory and turns its contents into writes on an internal register bus. The host programs the ring's base address and moves a write pointer forward in 16-byte steps. The block reads each 128-bit entry through a simple memory read port and advances its own read pointer, which the host can see. It stops fetching when the two pointers meet. The ring size is a power of two, and both pointers wrap at that size.

Each entry holds four 32-bit words, and word 0 sits in bits 31:0. The words form a stream of tagged headers and data words: a single-register write, a burst of writes to consecutive registers, or a filler word. A write to the command register also sends a one-cycle start pulse and the command word to a drawing engine. Decoding then holds until the engine reports that it is done. A 32-bit status word reports whether the queue is empty and whether the engine is idle, together with a sticky error flag and three 8-bit activity counters.

Top module: `cmdq_engine`

## Requirements
- R1: After reset, the read pointer is 0, no register write is issued, and the status word is 0xE4000000: bits 31, 30, 29 and 26 are set and every counter is zero.
- R2: A header word whose upper 16 bits are 0x1680 writes the following word to the register offset in the header's lower 16 bits. The two halves of an entry (words 0/1, then words 2/3) give two such writes, in that order.
- R3: A word whose upper 16 bits are 0x168F is a filler and causes no register write. An entry made only of fillers causes none at all.
- R4: A header with upper bits 0x568A and a start offset, followed by a word with upper bits 0x6210 and a count N in its lower 16 bits, writes the next N words to offsets start, start+4, start+8, and so on. The burst may continue into the next entry.
- R5: Entries are read from base + read pointer. The read pointer advances by 16 for each entry, wraps to 0 at the ring size, and fetching stops when it equals the write pointer. Every read address shares its upper bits with the base.
- R6: A host write to offset 0x85C0 sets the base, and a write to 0x85C4 sets the write pointer (its lower 4 bits are forced to zero). Host writes to any other offset, including 0x85C8, change neither pointer and leave the status word unchanged.
- R7: A register write to offset 0x823C raises eng_start for exactly one cycle, in the same cycle as the register write, with eng_cmd equal to the data word.
- R8: After a start, no further register write is issued and status bit 29 stays low until eng_done is seen. Decoding then resumes where it stopped.
- R9: A header with any other tag is dropped together with the word after it. Status bit 24 is then set and stays set until reset.
- R10: Status bit 26 is set when read pointer equals write pointer. Bit 30 is set when, in addition, no entry is held or being fetched. Bit 31 is set when bit 30 is set and the engine is idle.
- R11: Status bits 7:0 count entries consumed, bits 15:8 count register writes and bits 23:16 count engine starts. Each counter wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 16 | Host register offset |
| host_wdata | input | 32 | Host write data |
| rd_ptr_o | output | log2(QBYTES) | Hardware read pointer (byte offset in ring) |
| status_o | output | 32 | Status word |
| mem_req | output | 1 | One-cycle read request for one entry |
| mem_addr | output | AW | Byte address of the requested entry |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Entry data, word 0 in bits 31:0 |
| reg_we | output | 1 | Internal register write strobe |
| reg_addr | output | 16 | Internal register offset |
| reg_wdata | output | 32 | Internal register data |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_cmd | output | 32 | Latched command word |
| eng_done | input | 1 | Engine completion pulse |

## Verification
The bench targets the following corner cases:
- A burst whose data crosses into a second entry. A decoder that resets its state at each entry would drop or misroute the last three writes.
- A header with an unknown tag followed by a word that looks like a valid header. A design that skipped only the bad header would issue an extra write to offset 0x8220.
- A slow engine. A missing stall would let the register write after the command leak out while status bit 29 is low.
- A long run of filler entries up to the end of the ring, followed by a real entry that wraps the read pointer to zero. Wrong pointer arithmetic would either hang or fetch outside the ring. The entry counter must also have wrapped to exactly zero by then.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;
   localparam logic [15:0] TAG_SINGLE = 16'h1680;
   localparam logic [15:0] TAG_FILL   = 16'h168F;
   localparam logic [15:0] TAG_BURST  = 16'h568A;
   localparam logic [15:0] TAG_COUNT  = 16'h6210;
   localparam logic [15:0] OFF_QBASE  = 16'h85C0;
   localparam logic [15:0] OFF_QWR    = 16'h85C4;
   localparam logic [15:0] OFF_CMD    = 16'h823C;
   localparam int WORD_W = 32;
   localparam int ENT_W  = 4 * WORD_W;
   localparam int CTR_W  = 8;
   localparam int NCTR   = 3;
   typedef enum logic [2:0] {M_HDR, M_DATA, M_CNT, M_BURST, M_SKIP} mode_t;
endpackage

// File: rtl/cmdq_fetch.sv
`timescale 1ns/1ps
module cmdq_fetch
   import cmdq_pkg::*;
#(
   parameter int PW = 12,
   parameter int AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     base,
   input  logic [PW-1:0]     wr_ptr,
   input  logic              ent_release,
   input  logic              mem_valid,
   input  logic [ENT_W-1:0]  mem_rdata,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   output logic              fetching,
   output logic              ent_valid,
   output logic [ENT_W-1:0]  ent_data,
   output logic [PW-1:0]     rd_ptr
);
   localparam logic [PW-1:0] STEP = PW'(16);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req   <= 1'b0;
         mem_addr  <= '0;
         fetching  <= 1'b0;
         ent_valid <= 1'b0;
         ent_data  <= '0;
         rd_ptr    <= '0;
      end else begin
         mem_req <= 1'b0;
         if (!ent_valid && !fetching && (rd_ptr != wr_ptr)) begin
            mem_req  <= 1'b1;
            mem_addr <= base + AW'(rd_ptr);
            fetching <= 1'b1;
         end
         if (fetching && mem_valid) begin
            ent_data  <= mem_rdata;
            ent_valid <= 1'b1;
            fetching  <= 1'b0;
            rd_ptr    <= rd_ptr + STEP;
         end
         if (ent_release) ent_valid <= 1'b0;
      end
   end

   assert_no_fetch_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> $past(rd_ptr != wr_ptr));
   assert_one_entry_in_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ent_valid);
endmodule

// File: rtl/cmdq_decode.sv
`timescale 1ns/1ps
module cmdq_decode
   import cmdq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ent_valid,
   input  logic [ENT_W-1:0]  ent_data,
   input  logic              eng_done,
   output logic              ent_release,
   output logic              reg_we,
   output logic [15:0]       reg_addr,
   output logic [WORD_W-1:0] reg_wdata,
   output logic              eng_start,
   output logic [WORD_W-1:0] eng_cmd,
   output logic              eng_busy,
   output logic              tag_err
);
   mode_t             mode;
   logic [1:0]        widx;
   logic [15:0]       cur_off;
   logic [15:0]       left;
   logic [WORD_W-1:0] word;
   logic              step;
   logic              do_write;

   assign step        = ent_valid && !eng_busy;
   assign ent_release = step && (widx == 2'd3);
   assign do_write    = step && ((mode == M_DATA) || (mode == M_BURST));

   always_comb begin
      unique case (widx)
         2'd0:    word = ent_data[31:0];
         2'd1:    word = ent_data[63:32];
         2'd2:    word = ent_data[95:64];
         default: word = ent_data[127:96];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= M_HDR;
         widx    <= 2'd0;
         cur_off <= '0;
         left    <= '0;
         tag_err <= 1'b0;
      end else begin
         tag_err <= 1'b0;
         if (step) begin
            widx <= widx + 2'd1;
            unique case (mode)
               M_HDR: begin
                  if (word[31:16] == TAG_SINGLE) begin
                     cur_off <= word[15:0];
                     mode    <= M_DATA;
                  end else if (word[31:16] == TAG_BURST) begin
                     cur_off <= word[15:0];
                     mode    <= M_CNT;
                  end else if (word[31:16] != TAG_FILL) begin
                     tag_err <= 1'b1;
                     mode    <= M_SKIP;
                  end
               end
               M_DATA: mode <= M_HDR;
               M_CNT: begin
                  if (word[31:16] == TAG_COUNT) begin
                     left <= word[15:0];
                     mode <= (word[15:0] == 16'd0) ? M_HDR : M_BURST;
                  end else begin
                     tag_err <= 1'b1;
                     mode    <= M_HDR;
                  end
               end
               M_BURST: begin
                  cur_off <= cur_off + 16'd4;
                  left    <= left - 16'd1;
                  if (left == 16'd1) mode <= M_HDR;
               end
               default: mode <= M_HDR;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_we    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         eng_start <= 1'b0;
         eng_cmd   <= '0;
         eng_busy  <= 1'b0;
      end else begin
         reg_we    <= do_write;
         eng_start <= 1'b0;
         if (eng_busy && eng_done) eng_busy <= 1'b0;
         if (do_write) begin
            reg_addr  <= cur_off;
            reg_wdata <= word;
            if (cur_off == OFF_CMD) begin
               eng_start <= 1'b1;
               eng_cmd   <= word;
               eng_busy  <= 1'b1;
            end
         end
      end
   end

   assert_start_has_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (reg_we && reg_addr == OFF_CMD));
   assert_start_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   assert_stall_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && !eng_done) |=> !reg_we);
endmodule

// File: rtl/cmdq_engine.sv
`timescale 1ns/1ps
module cmdq_engine
   import cmdq_pkg::*;
#(
   parameter int QBYTES = 4096,
   parameter int AW     = 32,
   localparam int PW    = $clog2(QBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [15:0]       host_addr,
   input  logic [31:0]       host_wdata,
   output logic [PW-1:0]     rd_ptr_o,
   output logic [31:0]       status_o,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_valid,
   input  logic [ENT_W-1:0]  mem_rdata,
   output logic              reg_we,
   output logic [15:0]       reg_addr,
   output logic [31:0]       reg_wdata,
   output logic              eng_start,
   output logic [31:0]       eng_cmd,
   input  logic              eng_done
);
   if ((QBYTES & (QBYTES - 1)) != 0 || QBYTES < 32) begin : g_bad_size
      $error("QBYTES must be a power of two of at least 32");
   end
   if (AW > 32 || AW <= PW) begin : g_bad_aw
      $error("AW must exceed the pointer width and fit in a host word");
   end

   logic [AW-1:0]    base_q;
   logic [PW-1:0]    wr_ptr_q;
   logic             ent_release, ent_valid, fetching, eng_busy, tag_err, err_q;
   logic [ENT_W-1:0] ent_data;
   logic [NCTR-1:0]  ctr_inc;
   logic             ptr_equal, q_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         wr_ptr_q <= '0;
      end else if (host_we) begin
         if (host_addr == OFF_QBASE) base_q <= host_wdata[AW-1:0];
         if (host_addr == OFF_QWR)   wr_ptr_q <= {host_wdata[PW-1:4], 4'b0000};
      end
   end

   cmdq_fetch #(.PW(PW), .AW(AW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .base(base_q), .wr_ptr(wr_ptr_q),
      .ent_release(ent_release), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .fetching(fetching),
      .ent_valid(ent_valid), .ent_data(ent_data), .rd_ptr(rd_ptr_o)
   );

   cmdq_decode u_decode (
      .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_data(ent_data),
      .eng_done(eng_done), .ent_release(ent_release), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .eng_start(eng_start),
      .eng_cmd(eng_cmd), .eng_busy(eng_busy), .tag_err(tag_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (tag_err) err_q <= 1'b1;
   end

   assign ctr_inc = {eng_start, reg_we, ent_release};

   for (genvar i = 0; i < NCTR; i++) begin : g_ctr
      logic [CTR_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)          cnt <= '0;
         else if (ctr_inc[i]) cnt <= cnt + 1'b1;
      end
   end

   assign ptr_equal = (rd_ptr_o == wr_ptr_q);
   assign q_empty   = ptr_equal && !ent_valid && !fetching;
   assign status_o  = {q_empty & ~eng_busy, q_empty, ~eng_busy, 2'b00, ptr_equal,
                       1'b0, err_q, g_ctr[2].cnt, g_ctr[1].cnt, g_ctr[0].cnt};

   assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !status_o[29]);
   assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(status_o[24]) |-> status_o[24]);
endmodule

// File: tb/cmdq_engine_test.sv
`timescale 1ns/1ps
module cmdq_engine_test;
   localparam int QB = 4096;
   localparam logic [31:0] BASE = 32'h0010_0000;
   localparam logic [31:0] FILL = 32'h168F_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_we = 1'b0;
   logic [15:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [11:0] rd_ptr_o;
   logic [31:0] status_o;
   logic mem_req, mem_valid;
   logic [31:0] mem_addr;
   logic [127:0] mem_rdata;
   logic reg_we, eng_start, eng_done;
   logic [15:0] reg_addr;
   logic [31:0] reg_wdata, eng_cmd;

   cmdq_engine #(.QBYTES(QB)) uut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .rd_ptr_o(rd_ptr_o), .status_o(status_o),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .eng_start(eng_start), .eng_cmd(eng_cmd),
      .eng_done(eng_done)
   );

   always #2.5 clk = ~clk;

   logic [127:0] mem [256];
   logic addr_bad = 1'b0;
   always @(posedge clk) begin
      mem_valid <= 1'b0;
      if (mem_req) begin
         mem_valid <= 1'b1;
         mem_rdata <= mem[mem_addr[11:4]];
         if (mem_addr[31:12] != BASE[31:12]) addr_bad <= 1'b1;
      end
   end

   int nlog = 0;
   logic [15:0] la [64];
   logic [31:0] ld [64];
   always @(posedge clk) if (reg_we) begin
      la[nlog % 64] <= reg_addr;
      ld[nlog % 64] <= reg_wdata;
      nlog <= nlog + 1;
   end

   int nstart = 0;
   logic [31:0] last_cmd = '0;
   logic prev_start = 1'b0, double_start = 1'b0;
   int done_delay = 3;
   int pend = 0;
   always @(posedge clk) begin
      eng_done   <= 1'b0;
      prev_start <= eng_start;
      if (eng_start && prev_start) double_start <= 1'b1;
      if (eng_start) begin
         nstart   <= nstart + 1;
         last_cmd <= eng_cmd;
         pend     <= done_delay;
      end else if (pend > 0) begin
         pend <= pend - 1;
         if (pend == 1) eng_done <= 1'b1;
      end
   end

   int nchk = 0, nfail = 0;
   int wp = 0, ents = 0, writes = 0, cmds = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic push(input logic [31:0] w0, w1, w2, w3);
      mem[wp / 16] = {w3, w2, w1, w0};
      wp = (wp + 16) % QB;
      ents++;
   endtask

   task automatic kick;
      host_wr(16'h85C4, 32'(wp));
   endtask

   task automatic wait_idle;
      int n = 0;
      repeat (3) @(negedge clk);
      while (!status_o[31] && n < 20000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 20000) chk("R10 idle timeout", 32'(n), 32'd0);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 status after reset", status_o, 32'hE400_0000);
      chk("R1 read pointer after reset", 32'(rd_ptr_o), 32'd0);
      chk("R1 no register write", 32'(nlog), 32'd0);
   endtask

   task automatic t_single;
      int n0 = nlog;
      push(32'h1680_8200, 32'hAAAA_0001, 32'h1680_8210, 32'h1234_5678);
      kick;
      chk("R10 bit26/30 low with work pending", {30'd0, status_o[26], status_o[30]}, 32'd0);
      wait_idle;
      writes += 2;
      chk("R2 write count", 32'(nlog - n0), 32'd2);
      chk("R2 first offset", 32'(la[n0 % 64]), 32'h8200);
      chk("R2 first data", ld[n0 % 64], 32'hAAAA_0001);
      chk("R2 second offset", 32'(la[(n0 + 1) % 64]), 32'h8210);
      chk("R2 second data", ld[(n0 + 1) % 64], 32'h1234_5678);
      chk("R5 read pointer follows", 32'(rd_ptr_o), 32'(wp));
      chk("R10 idle status bits", {29'd0, status_o[31:29]}, 32'd7);
      chk("R10 bit26 at idle", 32'(status_o[26]), 32'd1);
   endtask

   task automatic t_filler;
      int n0 = nlog;
      push(32'h1680_8204, 32'hCAFE_0002, FILL, FILL);
      push(FILL, FILL, FILL, FILL);
      kick;
      wait_idle;
      writes += 1;
      chk("R3 filler gives no write", 32'(nlog - n0), 32'd1);
      chk("R3 offset", 32'(la[n0 % 64]), 32'h8204);
      chk("R3 data", ld[n0 % 64], 32'hCAFE_0002);
   endtask

   task automatic t_burst;
      int n0 = nlog;
      push(32'h568A_8300, 32'h6210_0005, 32'h1111_0000, 32'h1111_0001);
      push(32'h1111_0002, 32'h1111_0003, 32'h1111_0004, FILL);
      kick;
      wait_idle;
      writes += 5;
      chk("R4 burst count", 32'(nlog - n0), 32'd5);
      for (int i = 0; i < 5; i++) begin
         chk("R4 burst offset", 32'(la[(n0 + i) % 64]), 32'h8300 + 32'(4 * i));
         chk("R4 burst data", ld[(n0 + i) % 64], 32'h1111_0000 + 32'(i));
      end
   endtask

   task automatic t_cmd;
      int n0 = nlog;
      int s0 = nstart;
      int n = 0;
      done_delay = 20;
      push(32'h1680_823C, 32'h0001_CC0A, 32'h1680_8218, 32'h0010_0020);
      kick;
      while (nstart == s0 && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R7 start seen", 32'(nstart - s0), 32'd1);
      chk("R7 command word", last_cmd, 32'h0001_CC0A);
      chk("R7 write to command offset", 32'(la[n0 % 64]), 32'h823C);
      repeat (5) @(negedge clk);
      chk("R8 engine busy bit", 32'(status_o[29]), 32'd0);
      chk("R10 all-idle low while busy", 32'(status_o[31]), 32'd0);
      chk("R8 decoding stalled", 32'(nlog - n0), 32'd1);
      wait_idle;
      writes += 2;
      cmds += 1;
      chk("R8 resumed after done", 32'(nlog - n0), 32'd2);
      chk("R8 resumed offset", 32'(la[(n0 + 1) % 64]), 32'h8218);
      chk("R7 single-cycle pulse", 32'(double_start), 32'd0);
      done_delay = 3;
   endtask

   task automatic t_error;
      int n0 = nlog;
      chk("R9 error clear before", 32'(status_o[24]), 32'd0);
      push(32'h1234_0000, 32'h1680_8220, 32'h1680_8224, 32'h0000_0055);
      kick;
      wait_idle;
      writes += 1;
      chk("R9 bad header and word skipped", 32'(nlog - n0), 32'd1);
      chk("R9 following offset", 32'(la[n0 % 64]), 32'h8224);
      chk("R9 following data", ld[n0 % 64], 32'h0000_0055);
      chk("R9 error flag set", 32'(status_o[24]), 32'd1);
      push(32'h1680_8230, 32'h0000_0077, FILL, FILL);
      kick;
      wait_idle;
      writes += 1;
      chk("R9 error flag sticky", 32'(status_o[24]), 32'd1);
   endtask

   task automatic t_ignore;
      logic [11:0] r0 = rd_ptr_o;
      logic [31:0] s0 = status_o;
      int n0 = nlog;
      host_wr(16'h85C8, 32'h0000_0000);
      host_wr(16'h85D0, 32'h0000_0FF0);
      repeat (10) @(negedge clk);
      chk("R6 read pointer unchanged", 32'(rd_ptr_o), 32'(r0));
      chk("R6 status unchanged", status_o, s0);
      chk("R6 no writes", 32'(nlog - n0), 32'd0);
   endtask

   task automatic t_wrap;
      int n0;
      ents += (QB - 16 - wp) / 16;
      wp = QB - 16;
      kick;
      wait_idle;
      chk("R5 read pointer at ring end", 32'(rd_ptr_o), 32'(QB - 16));
      n0 = nlog;
      push(32'h1680_8228, 32'h0BAD_F00D, FILL, FILL);
      kick;
      wait_idle;
      writes += 1;
      chk("R5 read pointer wrapped", 32'(rd_ptr_o), 32'd0);
      chk("R5 write after wrap", ld[n0 % 64], 32'h0BAD_F00D);
      chk("R5 addresses stay in ring", 32'(addr_bad), 32'd0);
   endtask

   task automatic t_counters;
      chk("R11 entry counter", 32'(status_o[7:0]), 32'(ents % 256));
      chk("R11 write counter", 32'(status_o[15:8]), 32'(writes % 256));
      chk("R11 start counter", 32'(status_o[23:16]), 32'(cmds % 256));
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      report;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = {FILL, FILL, FILL, FILL};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      host_wr(16'h85C0, BASE);
      t_single;
      t_filler;
      t_burst;
      t_cmd;
      t_error;
      t_ignore;
      t_wrap;
      t_counters;
      report;
   end
endmodule